// File: doc/BRIEF.md
# Legacy I/O Controller Configuration Register Decoder

This block holds the configuration registers of a legacy multi-function I/O controller and turns them into the decode information its peripherals need: a base I/O address and an enable for the floppy controller, the two serial ports, the parallel port and the IDE channel, plus the parallel-port mode bits, its FIFO threshold and the DMA channel selections. The peripherals themselves sit outside.

Software reaches the registers through two ports that share a bus. A write to the index port picks a register number. Reads and writes on the data port then act on that register. The unlock key sequence is replaced by a single `cfg_mode` input: while it is low, both ports ignore all traffic. Some registers have only a subset of writable bits. A lock bit can freeze the low sixteen registers until the next reset. Every decoded output is a combinational function of the register contents, so it changes in the cycle right after the write edge.

Top module: `sio_cfg_decoder`

## Requirements
- R1: After reset, register 0x01 reads 0x80, register 0x21 reads 0x3C, register 0x22 reads 0x3D and every other register reads 0x00. So right after reset ide_pri_base is 0x0F0, ide_sec_base is 0x0F6 and fdc_en is 0.
- R2: A write with acc_sel=0 latches acc_wdata as the register index. With acc_sel=1, a write stores into the indexed register and a read (acc_rd=1) returns it on acc_rdata. A read with acc_sel=0 returns the index. While cfg_mode is 0, writes change nothing and acc_rdata is 0x00.
- R3: A write to register 0x00 updates only the bits in mask 0x8B. The bits in mask 0x74 keep their previous value.
- R4: A write to register 0x01 updates only the bits in mask 0x8C. The bits in mask 0x73 keep their previous value.
- R5: While bit 7 of register 0x01 is 0, writes to registers 0x00 through 0x0F are ignored. Registers 0x10 and above stay writable. Because register 0x01 is itself locked, the lock holds until reset.
- R6: fdc_base is register 0x20 shifted left by 2. fdc_en is 1 exactly when bit 7 or bit 6 of register 0x20 is set.
- R7: ide_pri_base is (reg 0x21 AND 0xFC) shifted left by 2. ide_sec_base is ((reg 0x22 AND 0xFC) shifted left by 2) OR 0x006. ide_en is 1 only when bits 1:0 of register 0x00 equal 2'b10.
- R8: lpt_en is 1 when bit 2 of register 0x01 is set and register 0x23 is at least 0x40. lpt_base is register 0x23 shifted left by 2, with bit 0 of register 0x23 forced to 0 first when bit 0 of register 0x04 is set.
- R9: When bit 3 of register 0x01 is set, lpt_ext, lpt_epp and lpt_ecp are all 0. Otherwise lpt_ext is 1, lpt_epp equals bit 0 of register 0x04 and lpt_ecp equals bit 1 of register 0x04.
- R10: lpt_fifo_thr equals bits 3:0 of register 0x0A. Only those bits of 0x0A are writable; bits 7:4 read 0.
- R11: fdc_dma equals bits 7:4 of register 0x26, and lpt_dma equals bits 3:0.
- R12: uart0_base and uart1_base are registers 0x24 and 0x25 shifted left by 2. uart_en[0] and uart_en[1] are 1 when bit 7 or bit 6 of their register is set.
- R13: An index at or above NUM_REGS names no register. Data writes to it are dropped and data reads return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | Configuration access open |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe |
| acc_sel | input | 1 | 0 = index port, 1 = data port |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data |
| fdc_en | output | 1 | Floppy decode enable |
| fdc_base | output | 10 | Floppy base address |
| uart_en | output | 2 | Serial port decode enables |
| uart0_base | output | 10 | Serial port 0 base address |
| uart1_base | output | 10 | Serial port 1 base address |
| lpt_en | output | 1 | Parallel port decode enable |
| lpt_base | output | 10 | Parallel port base address |
| lpt_ext | output | 1 | Extended parallel mode |
| lpt_epp | output | 1 | Enhanced parallel mode |
| lpt_ecp | output | 1 | Extended-capability parallel mode |
| lpt_fifo_thr | output | 4 | Parallel FIFO threshold |
| ide_en | output | 1 | IDE decode enable |
| ide_pri_base | output | 10 | IDE primary base |
| ide_sec_base | output | 10 | IDE secondary base |
| fdc_dma | output | 4 | Floppy DMA channel |
| lpt_dma | output | 4 | Parallel DMA channel |

## Verification
The bench builds the block with the default NUM_REGS of 48. That puts index 0x30 just past the last register, so the out-of-range drop and zero readback can be hit, and 0x2F serves as the top valid register. Since every decoded register lies inside that range, one build covers the lock boundary at 0x0F/0x10 as well as every decode path.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int REG_W  = 8;
  localparam int BASE_W = REG_W + 2;

  localparam logic [REG_W-1:0] IX_CTRL0  = 8'h00;
  localparam logic [REG_W-1:0] IX_CTRL1  = 8'h01;
  localparam logic [REG_W-1:0] IX_PMODE  = 8'h04;
  localparam logic [REG_W-1:0] IX_FIFO   = 8'h0A;
  localparam logic [REG_W-1:0] IX_FLOPPY = 8'h20;
  localparam logic [REG_W-1:0] IX_IDE_P  = 8'h21;
  localparam logic [REG_W-1:0] IX_IDE_S  = 8'h22;
  localparam logic [REG_W-1:0] IX_PAR    = 8'h23;
  localparam logic [REG_W-1:0] IX_SER0   = 8'h24;
  localparam logic [REG_W-1:0] IX_SER1   = 8'h25;
  localparam logic [REG_W-1:0] IX_DMA    = 8'h26;
  localparam logic [REG_W-1:0] LOCK_TOP  = 8'h0F;

  // Bits a data-port write may change.
  function automatic logic [REG_W-1:0] wr_mask(input int ix);
    case (ix)
      int'(IX_CTRL0): wr_mask = 8'h8B;
      int'(IX_CTRL1): wr_mask = 8'h8C;
      int'(IX_FIFO):  wr_mask = 8'h0F;
      default:        wr_mask = 8'hFF;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] rst_val(input int ix);
    case (ix)
      int'(IX_CTRL1): rst_val = 8'h80;
      int'(IX_IDE_P): rst_val = 8'h3C;
      int'(IX_IDE_S): rst_val = 8'h3D;
      default:        rst_val = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sio_cfg_regfile.sv
module sio_cfg_regfile
  import sio_cfg_pkg::*;
#(
  parameter int NUM_REGS = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_mode,
  input  logic             acc_wr,
  input  logic             acc_rd,
  input  logic             acc_sel,
  input  logic [REG_W-1:0] acc_wdata,
  output logic [REG_W-1:0] acc_rdata,
  output logic [REG_W-1:0] regs_q [NUM_REGS]
);
  logic [REG_W-1:0] idx_q;
  logic [REG_W-1:0] sel_val;
  logic             locked;
  logic             data_wr;

  assign locked  = ~regs_q[int'(IX_CTRL1)][7];
  assign data_wr = cfg_mode & acc_wr & acc_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           idx_q <= '0;
    else if (cfg_mode & acc_wr & ~acc_sel) idx_q <= acc_wdata;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [REG_W-1:0] MASK = wr_mask(i);
    localparam bit LOW = (i <= int'(LOCK_TOP));
    logic hit;
    assign hit = data_wr && (idx_q == REG_W'(i)) && !(LOW && locked);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs_q[i] <= rst_val(i);
      else if (hit) regs_q[i] <= (regs_q[i] & ~MASK) | (acc_wdata & MASK);
    end
  end

  always_comb begin
    sel_val = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx_q == REG_W'(i)) sel_val = regs_q[i];
  end

  always_comb begin
    if (!(cfg_mode && acc_rd)) acc_rdata = '0;
    else if (acc_sel)          acc_rdata = sel_val;
    else                       acc_rdata = idx_q;
  end

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && idx_q <= LOCK_TOP && locked) |=> $stable(sel_val)); // R5

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked); // R5

  AST_IDX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> $stable(idx_q)); // R2

  AST_CTRL0_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && idx_q == IX_CTRL0) |=>
      ((regs_q[0] & 8'h74) == $past(regs_q[0] & 8'h74))); // R3

  AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && acc_rd && acc_sel && idx_q >= REG_W'(NUM_REGS)) |-> acc_rdata == '0); // R13
endmodule

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode
  import sio_cfg_pkg::*;
(
  input  logic [REG_W-1:0]  ctrl0,
  input  logic [REG_W-1:0]  ctrl1,
  input  logic [REG_W-1:0]  pmode,
  input  logic [REG_W-1:0]  fifo,
  input  logic [REG_W-1:0]  floppy,
  input  logic [REG_W-1:0]  ide_p,
  input  logic [REG_W-1:0]  ide_s,
  input  logic [REG_W-1:0]  par,
  input  logic [REG_W-1:0]  dma,
  input  logic [REG_W-1:0]  ser   [2],
  output logic              fdc_en,
  output logic [BASE_W-1:0] fdc_base,
  output logic [1:0]        uart_en,
  output logic [BASE_W-1:0] uart_base [2],
  output logic              lpt_en,
  output logic [BASE_W-1:0] lpt_base,
  output logic              lpt_ext,
  output logic              lpt_epp,
  output logic              lpt_ecp,
  output logic [3:0]        lpt_fifo_thr,
  output logic              ide_en,
  output logic [BASE_W-1:0] ide_pri_base,
  output logic [BASE_W-1:0] ide_sec_base,
  output logic [3:0]        fdc_dma,
  output logic [3:0]        lpt_dma
);
  logic [REG_W-1:0] par_eff;
  logic             unused_bits;

  assign fdc_en   = |floppy[7:6];
  assign fdc_base = {floppy, 2'b00};

  for (genvar u = 0; u < 2; u++) begin : g_ser
    assign uart_en[u]   = |ser[u][7:6];
    assign uart_base[u] = {ser[u], 2'b00};
  end

  assign par_eff  = {par[7:1], par[0] & ~pmode[0]};
  assign lpt_en   = ctrl1[2] && (par >= 8'h40);
  assign lpt_base = {par_eff, 2'b00};

  assign lpt_ext = ~ctrl1[3];
  assign lpt_epp = ~ctrl1[3] & pmode[0];
  assign lpt_ecp = ~ctrl1[3] & pmode[1];
  assign lpt_fifo_thr = fifo[3:0];

  assign ide_en       = (ctrl0[1:0] == 2'b10);
  assign ide_pri_base = {ide_p[7:2], 4'b0000};
  assign ide_sec_base = {ide_s[7:2], 4'b0110};

  assign fdc_dma = dma[7:4];
  assign lpt_dma = dma[3:0];

  assign unused_bits = ^{ctrl0[7:2], ctrl1[7:4], ctrl1[1:0], pmode[7:2],
                         fifo[7:4], ide_p[1:0], ide_s[1:0]};
endmodule

// File: rtl/sio_cfg_decoder.sv
module sio_cfg_decoder
  import sio_cfg_pkg::*;
#(
  parameter int NUM_REGS = 48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_mode,
  input  logic        acc_wr,
  input  logic        acc_rd,
  input  logic        acc_sel,
  input  logic [7:0]  acc_wdata,
  output logic [7:0]  acc_rdata,
  output logic        fdc_en,
  output logic [9:0]  fdc_base,
  output logic [1:0]  uart_en,
  output logic [9:0]  uart0_base,
  output logic [9:0]  uart1_base,
  output logic        lpt_en,
  output logic [9:0]  lpt_base,
  output logic        lpt_ext,
  output logic        lpt_epp,
  output logic        lpt_ecp,
  output logic [3:0]  lpt_fifo_thr,
  output logic        ide_en,
  output logic [9:0]  ide_pri_base,
  output logic [9:0]  ide_sec_base,
  output logic [3:0]  fdc_dma,
  output logic [3:0]  lpt_dma
);
  logic [REG_W-1:0]  regs_q [NUM_REGS];
  logic [REG_W-1:0]  ser    [2];
  logic [BASE_W-1:0] ubase  [2];

  sio_cfg_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .acc_wr(acc_wr),
    .acc_rd(acc_rd), .acc_sel(acc_sel), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .regs_q(regs_q)
  );

  assign ser[0] = regs_q[int'(IX_SER0)];
  assign ser[1] = regs_q[int'(IX_SER1)];
  assign uart0_base = ubase[0];
  assign uart1_base = ubase[1];

  sio_cfg_decode u_dec (
    .ctrl0(regs_q[int'(IX_CTRL0)]), .ctrl1(regs_q[int'(IX_CTRL1)]),
    .pmode(regs_q[int'(IX_PMODE)]), .fifo(regs_q[int'(IX_FIFO)]),
    .floppy(regs_q[int'(IX_FLOPPY)]), .ide_p(regs_q[int'(IX_IDE_P)]),
    .ide_s(regs_q[int'(IX_IDE_S)]), .par(regs_q[int'(IX_PAR)]),
    .dma(regs_q[int'(IX_DMA)]), .ser(ser),
    .fdc_en(fdc_en), .fdc_base(fdc_base), .uart_en(uart_en), .uart_base(ubase),
    .lpt_en(lpt_en), .lpt_base(lpt_base), .lpt_ext(lpt_ext), .lpt_epp(lpt_epp),
    .lpt_ecp(lpt_ecp), .lpt_fifo_thr(lpt_fifo_thr), .ide_en(ide_en),
    .ide_pri_base(ide_pri_base), .ide_sec_base(ide_sec_base),
    .fdc_dma(fdc_dma), .lpt_dma(lpt_dma)
  );
endmodule

// File: tb/tb_sio_cfg_decoder.sv
module tb_sio_cfg_decoder;
  logic clk = 0, rst_n = 0, cfg_mode = 1, acc_wr = 0, acc_rd = 0, acc_sel = 0;
  logic [7:0] acc_wdata = 0, acc_rdata;
  logic fdc_en, lpt_en, lpt_ext, lpt_epp, lpt_ecp, ide_en;
  logic [1:0] uart_en;
  logic [9:0] fdc_base, uart0_base, uart1_base, lpt_base, ide_pri_base, ide_sec_base;
  logic [3:0] lpt_fifo_thr, fdc_dma, lpt_dma;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sio_cfg_decoder dut (.*);

  // {index, write data, expected readback}
  localparam logic [23:0] VEC [11] = '{
    24'h00_FF_8B,  // R3 only mask 0x8B lands
    24'h01_FF_8C,  // R4 only mask 0x8C lands
    24'h0A_FF_0F,  // R10 upper nibble read-only
    24'h20_FC_FC,
    24'h21_7D_7D,
    24'h23_79_79,
    24'h26_35_35,
    24'h04_03_03,
    24'h30_55_00,  // R13 out of range
    24'h2F_A5_A5,  // R2 top register
    24'h00_02_02   // R3
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    @(negedge clk); acc_wr = 1; acc_sel = sel; acc_wdata = d;
    @(negedge clk); acc_wr = 0;
  endtask

  task automatic wreg(logic [7:0] ix, logic [7:0] d);
    wr(0, ix); wr(1, d);
  endtask

  task automatic rreg(logic [7:0] ix, output logic [7:0] v);
    wr(0, ix);
    acc_rd = 1; acc_sel = 1; #1 v = acc_rdata; acc_rd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (2) @(negedge clk); rst_n = 1;
    // R1 reset state
    rreg(8'h01, v); chk("R1 reg01", v, 8'h80);
    rreg(8'h22, v); chk("R1 reg22", v, 8'h3D);
    rreg(8'h00, v); chk("R1 reg00", v, 8'h00);
    chk("R1 ide_pri", ide_pri_base, 10'h0F0);
    chk("R1 ide_sec", ide_sec_base, 10'h0F6);
    chk("R1 fdc_en", fdc_en, 0);

    foreach (VEC[k]) begin
      wreg(VEC[k][23:16], VEC[k][15:8]);
      rreg(VEC[k][23:16], v);
      chk("R2 table readback", v, VEC[k][7:0]);
    end
    acc_rd = 1; acc_sel = 0; #1 chk("R2 index read", acc_rdata, 8'h00); acc_rd = 0;

    chk("R6 fdc_en", fdc_en, 1);
    chk("R6 fdc_base", fdc_base, 10'h3F0);
    chk("R7 ide_en", ide_en, 1);
    chk("R7 ide_pri", ide_pri_base, 10'h1F0);
    chk("R7 ide_sec", ide_sec_base, 10'h0F6);
    chk("R8 lpt_en", lpt_en, 1);
    chk("R8 lpt_base masked", lpt_base, 10'h1E0);
    chk("R9 std mode", {lpt_ext, lpt_epp, lpt_ecp}, 3'b000);
    chk("R10 fifo", lpt_fifo_thr, 4'hF);
    chk("R11 fdc_dma", fdc_dma, 4'h3);
    chk("R11 lpt_dma", lpt_dma, 4'h5);

    wreg(8'h01, 8'h84);
    chk("R9 ext epp ecp", {lpt_ext, lpt_epp, lpt_ecp}, 3'b111);
    wreg(8'h04, 8'h02);
    chk("R9 epp off", {lpt_ext, lpt_epp, lpt_ecp}, 3'b101);
    chk("R8 lpt_base unmasked", lpt_base, 10'h1E4);
    wreg(8'h23, 8'h3F);
    chk("R8 lpt below 0x40", lpt_en, 0);
    wreg(8'h00, 8'h01);
    chk("R7 ide off", ide_en, 0);

    wreg(8'h24, 8'h40);
    wreg(8'h25, 8'h3F);
    chk("R12 uart_en", uart_en, 2'b01);
    chk("R12 uart0_base", uart0_base, 10'h100);
    chk("R12 uart1_base", uart1_base, 10'h0FC);

    // R2 config mode closed
    wr(0, 8'h24);
    cfg_mode = 0;
    wr(0, 8'h25); wr(1, 8'h00);
    acc_rd = 1; acc_sel = 1; #1 chk("R2 closed read", acc_rdata, 8'h00); acc_rd = 0;
    cfg_mode = 1;
    chk("R2 closed write", uart_en, 2'b01);
    acc_rd = 1; acc_sel = 0; #1 chk("R2 index kept", acc_rdata, 8'h24); acc_rd = 0;

    // R5 lock
    wreg(8'h01, 8'h04);
    wreg(8'h0A, 8'h03);
    chk("R5 locked fifo", lpt_fifo_thr, 4'hF);
    wreg(8'h01, 8'h80);
    rreg(8'h01, v); chk("R5 lock sticky", v, 8'h04);
    wreg(8'h20, 8'h00);
    chk("R5 high reg open", fdc_en, 0);

    // R1 again after a mid-run reset
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    rreg(8'h01, v); chk("R1 reg01 rerst", v, 8'h80);
    rreg(8'h21, v); chk("R1 reg21 rerst", v, 8'h3C);
    chk("R1 lpt_en rerst", lpt_en, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule